// File: doc/BRIEF.md
# Cascade Multi-Precision Multiplier

This block multiplies two unsigned 256-bit integers and returns the full 512-bit product. Both operands are held as eight 32-bit words in plain radix 2^32, with no redundant encoding. The work runs in rounds. Each round takes one word of A and multiplies it against every word of B, using two 32x32 multiplier lanes that each handle one B word per clock.

The B words are fed to the lanes in interleaved pairs: the pair of words 0 and 4 goes first, then 2 and 6, then 1 and 5, then 3 and 7. Each product is added into a 64-bit accumulator for its result word. After the four pair cycles of a round, a fold step runs:

- The lowest accumulator's low 32 bits leave as one finished product word.
- The high half of every accumulator is added to the low half of the word above it.
- The whole set moves down one place.

Carries above bit 32 are never rippled inside a round. One sequential pass at the end resolves the upper eight product words.

A user drives both operand buses, pulses `start_i` and waits for the one-cycle `done_o`. The product is then read from `product_o`, where word w sits at bits [32w+31:32w]. Operand words use the same layout on `a_i` and `b_i`.

Top module: `casc_mul`

## Requirements
- R1: During and after reset, `done_o` is 0 and `product_o` is all zeros.
- R2: When `done_o` is high, `product_o` equals the exact unsigned 512-bit product of the `a_i` and `b_i` values sampled when start was accepted. Word w of any bus sits at bits [32w+31:32w].
- R3: `start_i` is accepted on a rising clock edge only while the block is idle. `done_o` is high for exactly one cycle, following the 48th rising edge after the accepting edge.
- R4: `start_i` asserted while a multiplication is in progress has no effect on the running product or on when `done_o` appears.
- R5: `product_o` keeps its value from `done_o` until the next accepted start, whatever the operand inputs do.
- R6: No accumulator addition of a 32x32 product into a result word exceeds 64 bits, including for all-ones operands.
- R7: After every fold step, each accumulator word is at most 2^33-2.
- R8: The carry out of the final alignment pass is zero.
- R9: A start asserted on the edge that directly follows the `done_o` cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication; sampled only when idle |
| a_i | input | 256 | Multiplier A, eight 32-bit words, word 0 lowest |
| b_i | input | 256 | Multiplicand B, eight 32-bit words, word 0 lowest |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| product_o | output | 512 | Sixteen 32-bit product words, word 0 lowest |

## Verification
The product and `done_o` are both due 48 edges after the edge that accepted start. That count is eight rounds of five cycles each, plus eight alignment cycles. The bench's reference model mirrors only that count. It advances on each rising edge, and the bench compares `done_o` against it at every falling edge. At the falling edge where the model expects completion, `product_o` is compared with a behavioural 512-bit multiply. Hold, ignored-start and back-to-back cases are judged at those same falling edges, so every observation lies half a cycle after the register that produced it.

// File: rtl/casc_mul_pkg.sv
package casc_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_FOLD,
    ST_ALIGN
  } state_e;
endpackage

// File: rtl/casc_mul_lanes.sv
module casc_mul_lanes #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANES  = 2
) (
  input  logic [WORD_W-1:0]         a_word_i,
  input  logic [LANES*WORD_W-1:0]   b_words_i,
  output logic [LANES*2*WORD_W-1:0] prods_o
);
  localparam int unsigned PROD_W = 2 * WORD_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign prods_o[l*PROD_W +: PROD_W] =
      {{WORD_W{1'b0}}, a_word_i} * {{WORD_W{1'b0}}, b_words_i[l*WORD_W +: WORD_W]};
  end
endmodule

// File: rtl/casc_mul_ctrl.sv
module casc_mul_ctrl
  import casc_mul_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  output logic                          load_o,
  output logic                          mac_o,
  output logic [$clog2(NUM_WORDS)-2:0]  pair_o,
  output logic                          fold_o,
  output logic [$clog2(NUM_WORDS)-1:0]  round_o,
  output logic                          align_o,
  output logic                          align_last_o,
  output logic [$clog2(NUM_WORDS)-1:0]  align_idx_o,
  output logic                          done_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
  localparam int unsigned PAIR_W = IDX_W - 1;
  localparam logic [PAIR_W-1:0] PAIR_LAST = PAIR_W'(NUM_WORDS / 2 - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NUM_WORDS - 1);

  state_e             state_q;
  logic [PAIR_W-1:0]  pair_q;
  logic [IDX_W-1:0]   round_q, align_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pair_q  <= '0;
      round_q <= '0;
      align_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_MUL;
          pair_q  <= '0;
          round_q <= '0;
        end
        ST_MUL: begin
          pair_q <= pair_q + 1'b1;
          if (pair_q == PAIR_LAST) begin
            pair_q  <= '0;
            state_q <= ST_FOLD;
          end
        end
        ST_FOLD: begin
          if (round_q == IDX_LAST) begin
            state_q <= ST_ALIGN;
            align_q <= '0;
          end else begin
            round_q <= round_q + 1'b1;
            state_q <= ST_MUL;
          end
        end
        ST_ALIGN: begin
          align_q <= align_q + 1'b1;
          if (align_q == IDX_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Bit-reversed pair slot gives the interleaved order 0,2,1,3
  always_comb begin
    for (int i = 0; i < int'(PAIR_W); i++) pair_o[i] = pair_q[PAIR_W-1-i];
  end

  assign load_o       = (state_q == ST_IDLE) && start_i;
  assign mac_o        = (state_q == ST_MUL);
  assign fold_o       = (state_q == ST_FOLD);
  assign round_o      = round_q;
  assign align_o      = (state_q == ST_ALIGN);
  assign align_last_o = (state_q == ST_ALIGN) && (align_q == IDX_LAST);
  assign align_idx_o  = align_q;
  assign done_o       = done_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE));
  // R4
  restart_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !(state_q == ST_MUL && round_q == '0 && pair_q == '0));
endmodule

// File: rtl/casc_mul_acc.sv
module casc_mul_acc #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              mac_i,
  input  logic [$clog2(NUM_WORDS)-2:0]      pair_i,
  input  logic [2*WORD_W-1:0]               prod_lo_i,
  input  logic [2*WORD_W-1:0]               prod_hi_i,
  input  logic                              fold_i,
  output logic [WORD_W-1:0]                 low_word_o,
  output logic [NUM_WORDS*2*WORD_W-1:0]     acc_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
  localparam int unsigned ACC_W  = 2 * WORD_W;
  localparam logic [ACC_W-1:0] FOLD_MAX = (ACC_W'(1) << (WORD_W + 1)) - ACC_W'(2);

  logic [ACC_W-1:0] acc_q    [NUM_WORDS];
  logic [ACC_W-1:0] fold_nxt [NUM_WORDS];
  logic [IDX_W-1:0] lo_idx, hi_idx;
  logic [ACC_W:0]   sum_lo, sum_hi;

  assign lo_idx = {1'b0, pair_i};
  assign hi_idx = {1'b1, pair_i};
  assign sum_lo = {1'b0, acc_q[lo_idx]} + {1'b0, prod_lo_i};
  assign sum_hi = {1'b0, acc_q[hi_idx]} + {1'b0, prod_hi_i};

  // Shift down one word; each high half lands on the next word's low half
  always_comb begin
    for (int k = 0; k < int'(NUM_WORDS) - 1; k++) begin
      fold_nxt[k] = {{WORD_W{1'b0}}, acc_q[k+1][WORD_W-1:0]}
                  + {{WORD_W{1'b0}}, acc_q[k][ACC_W-1:WORD_W]};
    end
    fold_nxt[NUM_WORDS-1] = {{WORD_W{1'b0}}, acc_q[NUM_WORDS-1][ACC_W-1:WORD_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(NUM_WORDS); k++) acc_q[k] <= '0;
    end else if (clear_i) begin
      for (int k = 0; k < int'(NUM_WORDS); k++) acc_q[k] <= '0;
    end else if (mac_i) begin
      acc_q[lo_idx] <= sum_lo[ACC_W-1:0];
      acc_q[hi_idx] <= sum_hi[ACC_W-1:0];
    end else if (fold_i) begin
      for (int k = 0; k < int'(NUM_WORDS); k++) acc_q[k] <= fold_nxt[k];
    end
  end

  assign low_word_o = acc_q[0][WORD_W-1:0];

  always_comb begin
    for (int k = 0; k < int'(NUM_WORDS); k++) acc_o[k*ACC_W +: ACC_W] = acc_q[k];
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_i |-> (!sum_lo[ACC_W] && !sum_hi[ACC_W]));

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_bound
    // R7
    fold_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fold_i |=> (acc_q[k] <= FOLD_MAX));
  end
endmodule

// File: rtl/casc_mul_align.sv
module casc_mul_align #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  en_i,
  input  logic                  last_i,
  input  logic [2*WORD_W-1:0]   acc_word_i,
  output logic [WORD_W-1:0]     word_o
);
  localparam int unsigned ACC_W = 2 * WORD_W;

  logic [ACC_W-1:0] carry_q, sum;

  assign sum    = acc_word_i + carry_q;
  assign word_o = sum[WORD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      carry_q <= '0;
    else if (clear_i) carry_q <= '0;
    else if (en_i)    carry_q <= {{WORD_W{1'b0}}, sum[ACC_W-1:WORD_W]};
  end

  // R8
  final_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && last_i) |-> (sum[ACC_W-1:WORD_W] == '0));
endmodule

// File: rtl/casc_mul.sv
module casc_mul #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [WORD_W*NUM_WORDS-1:0]     a_i,
  input  logic [WORD_W*NUM_WORDS-1:0]     b_i,
  output logic                            done_o,
  output logic [2*WORD_W*NUM_WORDS-1:0]   product_o
);
  localparam int unsigned OP_W   = WORD_W * NUM_WORDS;
  localparam int unsigned ACC_W  = 2 * WORD_W;
  localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
  localparam int unsigned PAIR_W = IDX_W - 1;
  localparam int unsigned OUT_N  = 2 * NUM_WORDS;

  logic [OP_W-1:0]          a_q, b_q;
  logic [WORD_W-1:0]        prod_q [OUT_N];
  logic                     load, mac, fold, align, align_last;
  logic [PAIR_W-1:0]        pair;
  logic [IDX_W-1:0]         round, align_idx;
  logic [WORD_W-1:0]        a_word, low_word, align_word;
  logic [2*WORD_W-1:0]      b_pair;
  logic [2*ACC_W-1:0]       prods;
  logic [NUM_WORDS*ACC_W-1:0] acc_flat;

  casc_mul_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .load_o      (load),
    .mac_o       (mac),
    .pair_o      (pair),
    .fold_o      (fold),
    .round_o     (round),
    .align_o     (align),
    .align_last_o(align_last),
    .align_idx_o (align_idx),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_word = a_q[int'(round)*WORD_W +: WORD_W];
  assign b_pair = {b_q[int'({1'b1, pair})*WORD_W +: WORD_W],
                   b_q[int'({1'b0, pair})*WORD_W +: WORD_W]};

  casc_mul_lanes #(.WORD_W(WORD_W), .LANES(2)) u_lanes (
    .a_word_i (a_word),
    .b_words_i(b_pair),
    .prods_o  (prods)
  );

  casc_mul_acc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (load),
    .mac_i     (mac),
    .pair_i    (pair),
    .prod_lo_i (prods[0 +: ACC_W]),
    .prod_hi_i (prods[ACC_W +: ACC_W]),
    .fold_i    (fold),
    .low_word_o(low_word),
    .acc_o     (acc_flat)
  );

  casc_mul_align #(.WORD_W(WORD_W)) u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (load),
    .en_i      (align),
    .last_i    (align_last),
    .acc_word_i(acc_flat[int'(align_idx)*ACC_W +: ACC_W]),
    .word_o    (align_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < int'(OUT_N); w++) prod_q[w] <= '0;
    end else if (fold) begin
      prod_q[{1'b0, round}] <= low_word;
    end else if (align) begin
      prod_q[{1'b1, align_idx}] <= align_word;
    end
  end

  always_comb begin
    for (int w = 0; w < int'(OUT_N); w++) product_o[w*WORD_W +: WORD_W] = prod_q[w];
  end
endmodule

// File: tb/casc_mul_bench.sv
module casc_mul_bench;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 8;
  localparam int unsigned OP_W      = WORD_W * NUM_WORDS;
  localparam int unsigned LATENCY   = NUM_WORDS * (NUM_WORDS / 2 + 1) + NUM_WORDS;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [OP_W-1:0]   a_i = '0, b_i = '0;
  logic              done_o;
  logic [2*OP_W-1:0] product_o;

  int    n_checks = 0, n_fail = 0;
  bit    checking = 0, reported = 0;
  string tag = "R2";

  // reference model state
  bit            busy_m = 0, done_m = 0;
  int            cnt_m = 0;
  logic [2*OP_W-1:0] exp_m = '0;

  casc_mul #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_casc_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .done_o   (done_o),
    .product_o(product_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_m = 0; done_m = 0; cnt_m = 0;
    end else begin
      done_m = 0;
      if (busy_m) begin
        cnt_m++;
        if (cnt_m == int'(LATENCY)) begin busy_m = 0; done_m = 1; end
      end else if (start_i) begin
        busy_m = 1; cnt_m = 0;
        exp_m = {{OP_W{1'b0}}, a_i} * {{OP_W{1'b0}}, b_i};
      end
    end
  end

  task automatic check_prod(string t, logic [2*OP_W-1:0] got, logic [2*OP_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s product got %h exp %h", t, got, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk_i) begin
    if (checking) begin
      n_checks++;
      if (done_o !== done_m) begin
        n_fail++;
        $display("FAIL R3 done_o got %b exp %b", done_o, done_m);
      end
      if (done_m) check_prod(tag, product_o, exp_m);
    end
  end

  task automatic issue(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (done_m) break;
      @(negedge clk_i);
    end
  endtask

  function automatic logic [OP_W-1:0] rnd_op();
    logic [OP_W-1:0] v;
    for (int w = 0; w < int'(NUM_WORDS); w++) v[w*WORD_W +: WORD_W] = $urandom;
    return v;
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [2*OP_W-1:0] held;
    repeat (3) @(negedge clk_i);
    // R1
    check_prod("R1", product_o, '0);
    n_checks++;
    if (done_o !== 1'b0) begin n_fail++; $display("FAIL R1 done_o got %b exp 0", done_o); end
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_prod("R1", product_o, '0);
    checking = 1;

    tag = "R2"; issue('0, rnd_op()); wait_done();
    tag = "R6"; issue('1, '1); wait_done();
    tag = "R8"; issue('1, {{(OP_W-WORD_W){1'b1}}, 32'h0000_0001}); wait_done();
    tag = "R2"; issue(OP_W'(1), rnd_op()); wait_done();
    for (int k = 0; k < 6; k++) begin
      tag = "R2";
      issue(OP_W'(1) << (k * 45 + 3), OP_W'(1) << (255 - k * 37));
      wait_done();
    end
    tag = "R7"; issue({NUM_WORDS{32'hFFFF_FFFE}}, {NUM_WORDS{32'hFFFF_FFFF}}); wait_done();
    for (int k = 0; k < 5; k++) begin
      tag = "R2"; issue(rnd_op(), rnd_op()); wait_done();
    end

    // R4: start during a run must not disturb it
    tag = "R4";
    issue(rnd_op(), rnd_op());
    repeat (10) @(negedge clk_i);
    a_i = '1; b_i = rnd_op(); start_i = 1'b1;
    repeat (20) @(negedge clk_i);
    start_i = 1'b0;
    wait_done();

    // R5: product holds while operands change
    held = product_o;
    a_i = rnd_op(); b_i = rnd_op();
    repeat (6) @(negedge clk_i);
    check_prod("R5", product_o, held);

    // R9: restart in the cycle right after done
    tag = "R9"; issue(rnd_op(), rnd_op()); wait_done();
    issue('1, rnd_op()); wait_done();
    issue(rnd_op(), '1); wait_done();
    n_checks++;
    if (cnt_m != int'(LATENCY)) begin
      n_fail++;
      $display("FAIL R9 latency got %0d exp %0d", cnt_m, LATENCY);
    end

    repeat (3) @(negedge clk_i);
    report();
  end
endmodule